// File: doc/BRIEF.md
# Host-Readable Interrupt Record Queue

This block holds a first-in first-out list of interrupt records, one for each statistics counter that has crossed its threshold. The statistics engine pushes a record naming the counter (port, channel and counter number). A microprocessor drains the list over a simple synchronous register bus. Each read of the queue window returns the oldest record and advances the queue. The returned word also reports whether further records are waiting, so software can keep reading without going back to the status register.

A not-empty status bit drives a maskable interrupt pin. A counter window on the same bus passes counter values through from external storage. If the destructive-read control bit is set, every counter read also issues a clear request for that counter.

Clearing the engine-enable bit switches the block into maintenance mode. In this mode the queue stops popping and accepting records, and the host can read and write any storage location by index.

Top module: `irq_record_queue`

## Requirements
- R1: After reset, rdata_o, irq_o and clr_req_o are 0, the status register reads 0 and the control register reads 5 (bit0 enable=1, bit1 destructive=0, bit2 mask=1). The first record pushed after reset occupies location 0.
- R2: Status register (any address with bits[12:11]=00 and bit0=0) bit0 reads 1 exactly when at least one record is queued.
- R3: irq_o is 1 exactly when the not-empty bit is 1 and control bit2 (mask) is 0.
- R4: While enabled, a read at any address with bits[12:11]=01 returns the oldest record and removes it. Address bits[10:0] are ignored. The word is bit15 valid=1, bit14 more, bits[13:11]=0, bits[10:8] port, bits[7:3] channel, bits[2:0] counter number.
- R5: The more bit (bit14) of a popped word is 1 exactly when records remain after that pop.
- R6: A queue read while empty returns 16'h0000 and leaves the queue unchanged.
- R7: The queue holds 64 records. A push while full is dropped and sets sticky status bit1. Writing a 1 to status bit1 clears it.
- R8: A read with address bit12=1 returns cnt_val_i for counter id addr_i[10:0] (presented on cnt_id_o). If the destructive bit is 1, clr_req_o pulses for one cycle after the read with clr_id_o equal to that id. Otherwise clr_req_o stays 0.
- R9: With the enable bit 0, a queue-window read returns {5'b0, location[addr_i[5:0]]} without popping. A queue-window write stores wdata_i[10:0] at that location. Engine pushes are dropped without setting overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Engine record push strobe |
| ev_id_i | input | 11 | Counter id to enqueue {port, channel, counter} |
| addr_i | input | 13 | Host address |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data, valid the cycle after rd_i |
| cnt_id_o | output | 11 | Counter id addressed by the host |
| cnt_val_i | input | 16 | Counter value for cnt_id_o |
| irq_o | output | 1 | Interrupt request |
| clr_req_o | output | 1 | Counter clear request pulse |
| clr_id_o | output | 11 | Counter id to clear |

## Verification
The properties assume that rd_i and wr_i are never high in the same cycle. They also assume that host strobes last exactly one cycle per access, so each strobe is one bus transaction. The bench drives every access from a single task that raises one strobe for one clock and lowers it before the next. Engine pushes are issued in cycles of their own and never coincide with a host access, so a pop is never credited with a same-cycle push. The ordering of records and of the more bit therefore follows from the sequence of calls alone.

// File: rtl/irq_queue_pkg.sv
package irq_queue_pkg;
  typedef enum logic [1:0] {RGN_REG, RGN_QUEUE, RGN_CNT} region_e;

  function automatic region_e region_of(logic [1:0] top);
    if (top[1]) return RGN_CNT;
    else if (top[0]) return RGN_QUEUE;
    else return RGN_REG;
  endfunction
endpackage

// File: rtl/irq_queue_store.sv
module irq_queue_store #(
  parameter int DEPTH = 64,
  parameter int ID_W  = 11,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [ID_W-1:0]  wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [ID_W-1:0]  rdata_o
);
  logic [ID_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[g] <= '0;
      else if (we_i && waddr_i == IDX_W'(g)) mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/irq_queue_ptrs.sv
module irq_queue_ptrs #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             ovf_clr_i,
  output logic [IDX_W-1:0] wr_ptr_o,
  output logic [IDX_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             push_ok_o,
  output logic             ovf_o
);
  logic full, pop_ok;

  function automatic logic [IDX_W-1:0] step(logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count_o == CNT_W'(DEPTH));
  assign pop_ok    = pop_i && (count_o != '0);
  assign push_ok_o = push_i && (!full || pop_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_o <= '0;
      rd_ptr_o <= '0;
      count_o  <= '0;
      ovf_o    <= 1'b0;
    end else begin
      if (push_ok_o) wr_ptr_o <= step(wr_ptr_o);
      if (pop_ok)    rd_ptr_o <= step(rd_ptr_o);
      count_o <= count_o + CNT_W'(push_ok_o) - CNT_W'(pop_ok);
      if (push_i && !push_ok_o) ovf_o <= 1'b1;  // set wins over clear
      else if (ovf_clr_i)       ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_queue_host.sv
module irq_queue_host
  import irq_queue_pkg::*;
#(
  parameter int ID_W   = 11,
  parameter int DATA_W = 16,
  localparam int ADDR_W = ID_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [2:0]        ctl_wdata_i,
  input  logic              ne_i,
  input  logic              ovf_i,
  input  logic              more_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [DATA_W-1:0] cnt_val_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pop_o,
  output logic              maint_we_o,
  output logic              ovf_clr_o,
  output logic              en_o,
  output logic              mask_o,
  output logic              clr_req_o,
  output logic [ID_W-1:0]   clr_id_o
);
  region_e rgn;
  logic dest_q, ctl_we;
  logic [DATA_W-1:0] rd_word;

  assign rgn        = region_of(addr_i[ADDR_W-1 -: 2]);
  assign pop_o      = rd_i && rgn == RGN_QUEUE && en_o && ne_i;
  assign maint_we_o = wr_i && rgn == RGN_QUEUE && !en_o;
  assign ovf_clr_o  = wr_i && rgn == RGN_REG && !addr_i[0] && ctl_wdata_i[1];
  assign ctl_we     = wr_i && rgn == RGN_REG && addr_i[0];

  always_comb begin
    rd_word = '0;
    unique case (rgn)
      RGN_REG: begin
        if (addr_i[0]) rd_word[2:0] = {mask_o, dest_q, en_o};
        else           rd_word[1:0] = {ovf_i, ne_i};
      end
      RGN_QUEUE: begin
        if (!en_o) rd_word[ID_W-1:0] = id_i;
        else if (ne_i) begin
          rd_word[DATA_W-1]  = 1'b1;
          rd_word[DATA_W-2]  = more_i;
          rd_word[ID_W-1:0]  = id_i;
        end
      end
      default: rd_word = cnt_val_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      en_o      <= 1'b1;
      dest_q    <= 1'b0;
      mask_o    <= 1'b1;
      clr_req_o <= 1'b0;
      clr_id_o  <= '0;
    end else begin
      if (rd_i) rdata_o <= rd_word;
      if (ctl_we) {mask_o, dest_q, en_o} <= ctl_wdata_i;
      clr_req_o <= rd_i && rgn == RGN_CNT && dest_q;
      if (rd_i && rgn == RGN_CNT && dest_q) clr_id_o <= addr_i[ID_W-1:0];
    end
  end
endmodule

// File: rtl/irq_record_queue.sv
module irq_record_queue #(
  parameter int DEPTH  = 64,
  parameter int PORT_W = 3,
  parameter int CHAN_W = 5,
  parameter int CNUM_W = 3,
  parameter int DATA_W = 16,
  localparam int ID_W   = PORT_W + CHAN_W + CNUM_W,
  localparam int ADDR_W = ID_W + 2,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  logic [ID_W-1:0]   ev_id_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ID_W-1:0]   cnt_id_o,
  input  logic [DATA_W-1:0] cnt_val_i,
  output logic              irq_o,
  output logic              clr_req_o,
  output logic [ID_W-1:0]   clr_id_o
);
  logic [IDX_W-1:0] wr_ptr, rd_ptr, raddr, waddr;
  logic [CNT_W-1:0] count;
  logic [ID_W-1:0]  head_id, st_wdata;
  logic push_ok, pop, maint_we, ovf_clr, ovf, en, mask, ne, more;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:ID_W];
  assign ne       = (count != '0);
  assign more     = (count > CNT_W'(1)) || push_ok;
  assign irq_o    = ne && !mask;
  assign cnt_id_o = addr_i[ID_W-1:0];
  assign raddr    = en ? rd_ptr : addr_i[IDX_W-1:0];
  assign waddr    = push_ok ? wr_ptr : addr_i[IDX_W-1:0];
  assign st_wdata = push_ok ? ev_id_i : wdata_i[ID_W-1:0];

  irq_queue_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i, .rst_ni,
    .push_i(ev_valid_i && en), .pop_i(pop), .ovf_clr_i(ovf_clr),
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr), .count_o(count),
    .push_ok_o(push_ok), .ovf_o(ovf)
  );

  irq_queue_store #(.DEPTH(DEPTH), .ID_W(ID_W)) u_store (
    .clk_i, .rst_ni,
    .we_i(push_ok || maint_we), .waddr_i(waddr), .wdata_i(st_wdata),
    .raddr_i(raddr), .rdata_o(head_id)
  );

  irq_queue_host #(.ID_W(ID_W), .DATA_W(DATA_W)) u_host (
    .clk_i, .rst_ni,
    .addr_i, .rd_i, .wr_i, .ctl_wdata_i(wdata_i[2:0]),
    .ne_i(ne), .ovf_i(ovf), .more_i(more), .id_i(head_id),
    .cnt_val_i,
    .rdata_o, .pop_o(pop), .maint_we_o(maint_we), .ovf_clr_o(ovf_clr),
    .en_o(en), .mask_o(mask), .clr_req_o, .clr_id_o
  );
endmodule

// File: rtl/irq_record_queue_chk.sv
module irq_record_queue_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_i,
  input logic [1:0]       addr_top_i,
  input logic             rvalid_i,
  input logic             irq_i,
  input logic             clr_req_i,
  input logic [CNT_W-1:0] count_i,
  input logic             ovf_i,
  input logic             ovf_clr_i,
  input logic             en_i,
  input logic             mask_i,
  input logic             push_ok_i
);
  p_irq_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (count_i != '0) && !mask_i);

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(DEPTH));

  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i && !ovf_clr_i |=> ovf_i);

  p_pop_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_top_i == 2'b01 && en_i && count_i != '0 && !push_ok_i
    |=> count_i == $past(count_i) - 1'b1);

  p_empty_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_top_i == 2'b01 && en_i && count_i == '0 |=> !rvalid_i);

  p_maint_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(count_i));

  p_clr_after_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req_i |-> $past(rd_i));
endmodule

bind irq_record_queue irq_record_queue_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i),
  .addr_top_i(addr_i[ADDR_W-1 -: 2]), .rvalid_i(rdata_o[DATA_W-1]),
  .irq_i(irq_o), .clr_req_i(clr_req_o), .count_i(count), .ovf_i(ovf),
  .ovf_clr_i(ovf_clr), .en_i(en), .mask_i(mask), .push_ok_i(push_ok)
);

// File: tb/irq_record_queue_test.sv
module irq_record_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam logic [12:0] A_STAT = 13'h0000, A_CTL = 13'h0001, A_Q = 13'h0800, A_CNT = 13'h1000;
  localparam logic [1:0] OP_PUSH = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
  localparam int N_VEC = 21;
  // {op, req, irq_exp, addr, value}
  localparam logic [35:0] VEC [N_VEC] = '{
    {OP_RD,   4'd2, 1'b0, A_STAT, 16'h0000},   // R2 empty
    {OP_PUSH, 4'd0, 1'b0, 13'h0,  16'h0123},
    {OP_PUSH, 4'd0, 1'b0, 13'h0,  16'h0045},
    {OP_PUSH, 4'd0, 1'b0, 13'h0,  16'h07FF},
    {OP_RD,   4'd2, 1'b0, A_STAT, 16'h0001},   // R2 not empty, masked
    {OP_WR,   4'd0, 1'b0, A_CTL,  16'h0001},
    {OP_RD,   4'd3, 1'b1, A_STAT, 16'h0001},   // R3 unmasked
    {OP_RD,   4'd4, 1'b1, 13'h0800, 16'hC123}, // R4
    {OP_RD,   4'd4, 1'b1, 13'h083F, 16'hC045}, // R4 low bits ignored
    {OP_RD,   4'd5, 1'b0, 13'h0815, 16'h87FF}, // R5 last
    {OP_RD,   4'd6, 1'b0, 13'h0800, 16'h0000}, // R6 empty read
    {OP_RD,   4'd6, 1'b0, A_STAT, 16'h0000},   // R6 unchanged
    {OP_PUSH, 4'd0, 1'b0, 13'h0,  16'h00AA},
    {OP_RD,   4'd3, 1'b1, A_CTL,  16'h0001},   // R3
    {OP_WR,   4'd0, 1'b0, A_CTL,  16'h0005},
    {OP_RD,   4'd3, 1'b0, A_STAT, 16'h0001},   // R3 masked
    {OP_RD,   4'd4, 1'b0, 13'h0801, 16'h80AA}, // R4
    {OP_PUSH, 4'd0, 1'b0, 13'h0,  16'h0155},
    {OP_PUSH, 4'd0, 1'b0, 13'h0,  16'h02AA},
    {OP_RD,   4'd5, 1'b0, 13'h0800, 16'hC155}, // R5 more
    {OP_RD,   4'd5, 1'b0, 13'h0800, 16'h82AA}  // R5 none
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [10:0] ev_id = '0, cnt_id, clr_id;
  logic [12:0] addr = '0;
  logic [15:0] wdata = '0, rdata, cnt_val;
  logic irq, clr_req;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign cnt_val = 16'hA000 | {5'd0, cnt_id};

  irq_record_queue uut (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(ev_valid), .ev_id_i(ev_id),
    .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .cnt_id_o(cnt_id), .cnt_val_i(cnt_val), .irq_o(irq),
    .clr_req_o(clr_req), .clr_id_o(clr_id)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_push(input logic [10:0] id);
    ev_valid = 1'b1; ev_id = id; tick(); ev_valid = 1'b0;
  endtask

  task automatic do_wr(input logic [12:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1; tick(); wr = 1'b0;
  endtask

  task automatic do_rd(input logic [12:0] a, input logic [15:0] exp, input string req);
    addr = a; rd = 1'b1; tick(); rd = 1'b0;
    check(rdata === exp, req, rdata, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ev_valid = 1'b0; rd = 1'b0; wr = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1; tick();
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check(rdata === 16'h0 && irq === 1'b0 && clr_req === 1'b0, "R1 outputs",
          {rdata[15:2], irq, clr_req}, 16'h0);
    do_rd(A_CTL, 16'h0005, "R1 control");
    do_rd(A_STAT, 16'h0000, "R1 status");

    for (int i = 0; i < N_VEC; i++) begin
      logic [1:0] op; logic [3:0] rq; logic ie; logic [12:0] a; logic [15:0] v;
      {op, rq, ie, a, v} = VEC[i];
      case (op)
        OP_PUSH: do_push(v[10:0]);
        OP_WR:   do_wr(a, v);
        default: begin
          do_rd(a, v, $sformatf("R%0d vec%0d data", rq, i));
          check(irq === ie, $sformatf("R%0d vec%0d irq", rq, i), {15'd0, irq}, {15'd0, ie});
        end
      endcase
    end

    // R8 destructive counter read
    do_wr(A_CTL, 16'h0003);
    do_rd(A_CNT | 13'h02A5, 16'hA2A5, "R8 value");
    check(clr_req === 1'b1 && clr_id === 11'h2A5, "R8 clear pulse", {4'd0, clr_req, clr_id}, 16'h0AA5);
    tick();
    check(clr_req === 1'b0, "R8 pulse ends", {15'd0, clr_req}, 16'h0);
    do_wr(A_CTL, 16'h0001);
    do_rd(A_CNT | 13'h0013, 16'hA013, "R8 plain value");
    check(clr_req === 1'b0, "R8 no clear", {15'd0, clr_req}, 16'h0);

    // R7 overflow
    for (int i = 0; i < 65; i++) do_push(11'(i));
    do_rd(A_STAT, 16'h0003, "R7 full status");
    for (int i = 0; i < 64; i++)
      do_rd(A_Q | 13'(i), {1'b1, i != 63, 3'b000, 11'(i)}, "R7 pop order");
    do_rd(A_Q, 16'h0000, "R7 dropped push");
    do_rd(A_STAT, 16'h0002, "R7 sticky");
    do_wr(A_STAT, 16'h0002);
    do_rd(A_STAT, 16'h0000, "R7 cleared");

    // R9 maintenance access
    do_reset();
    do_push(11'h011);
    do_push(11'h022);
    do_wr(A_CTL, 16'h0000);
    do_rd(A_Q | 13'h0000, 16'h0011, "R9 direct read");
    do_wr(A_Q | 13'h0001, 16'hFD55);
    do_rd(A_Q | 13'h0001, 16'h0555, "R9 direct write");
    do_rd(A_Q | 13'h0001, 16'h0555, "R9 no pop");
    do_push(11'h033);
    do_rd(A_STAT, 16'h0001, "R9 push dropped, no overflow");
    do_wr(A_CTL, 16'h0001);
    do_rd(A_Q, 16'hC011, "R9 order kept");
    do_rd(A_Q, 16'h8555, "R9 edited entry");
    do_rd(A_Q, 16'h0000, "R9 count kept");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule